// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the slave end of a two-wire serial bus in front of a 2 KB byte store. It oversamples the clock and data lines with a fast system clock and finds the bus start and stop conditions. It accepts a control byte whose upper nibble selects the device and whose next three bits select a 256-byte block. The store is written one byte at a time inside a 16-byte page, and it is read back as a stream that walks the whole 11-bit address space.

The data line is open-drain. The block never drives it high. It only asserts a pull-low request, and the board or bench resolves the line as the master's level ANDed with the inverse of that request. A register array stands in for the nonvolatile cells, so writes complete at once and there is no busy period.

Top module: `twowire_eeprom_slave`

## Requirements
- R1: A falling data line while the clock line is high (START) enters control-byte reception from any state. A rising data line while the clock is high (STOP) returns the block to idle with the data line released.
- R2: Received bits are taken on clock rising edges, most significant bit first. The pull-low output changes only while the clock line is low.
- R3: A control byte whose bits 7..4 differ from 4'b1010 is not acknowledged. The block then stays idle and pulls nothing until the next START.
- R4: Control byte bits 3..1 become address bits 10..8. Control bit 0 = 1 starts a read at once from the current low address byte, with no word address received.
- R5: After a control byte with bit 0 = 0, the next byte loads address bits 7..0, and each byte after that is stored at the current address.
- R6: After each stored byte only address bits 3..0 advance, so writes wrap inside a 16-byte page (0x20F is followed by 0x200).
- R7: Each byte loaded for reading advances the full 11-bit address, which wraps from 0x7FF to 0x000.
- R8: Every received byte that is accepted (control, address or data) is acknowledged by pulling the data line low for the ninth clock.
- R9: After each byte sent, a master acknowledge (data low on the ninth clock) makes the block send the next byte. A master no-acknowledge (data high) returns it to idle with the line released.
- R10: While and after reset the data line is released (sda_pull_o = 0) and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Resolved serial data line level |
| sda_pull_o | output | 1 | 1 = pull the data line low, 0 = release it |

## Verification
A serial clock edge passes through two synchroniser flops and one edge-compare flop before the state registers act on it. The pull-low output therefore moves on the third system clock edge after the serial clock falls. The bench holds each serial clock phase for 24 system clocks and reads the data line in the middle of the high phase, well after every response has settled and long before the next falling edge. A bench monitor separately flags any change of the pull output while the clock line is high.

// File: rtl/twowire_eeprom_pkg.sv
package twowire_eeprom_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_WADDR,
    ST_WDATA,
    ST_SEND,
    ST_MACK
  } ee_state_e;
endpackage

// File: rtl/twowire_line_sync.sv
module twowire_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_q, sda_q, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_q  <= scl_sh[STAGES-1];
      sda_q  <= sda_sh[STAGES-1];
    end
  end

  assign scl_s     = scl_sh[STAGES-1];
  assign sda_lvl   = sda_sh[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_lvl;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_lvl;
endmodule

// File: rtl/twowire_byte_store.sv
module twowire_byte_store #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/twowire_slave_fsm.sv
module twowire_slave_fsm
  import twowire_eeprom_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [7:0]        rdata,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [ADDR_W-1:0] addr_o,
  output logic [7:0]        wdata,
  output logic              mem_we,
  output logic              rd_load,
  output logic              pull_o,
  output ee_state_e         state_o
);
  localparam int BLK_W = ADDR_W - 8;
  localparam logic [3:0] DEV_ID = 4'b1010;

  ee_state_e         state_q, state_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [7:0]        rx_q, rx_n, tx_q, tx_n;
  logic [3:0]        cnt_q, cnt_n;
  logic              pull_q, pull_n;
  logic              rx_state;

  assign rx_state = (state_q == ST_CTRL) || (state_q == ST_WADDR) || (state_q == ST_WDATA);
  assign rd_addr  = (state_q == ST_CTRL) ? {rx_q[BLK_W:1], addr_q[7:0]} : addr_q;

  always_comb begin
    state_n = state_q;
    addr_n  = addr_q;
    rx_n    = rx_q;
    tx_n    = tx_q;
    cnt_n   = cnt_q;
    pull_n  = pull_q;
    mem_we  = 1'b0;
    rd_load = 1'b0;
    if (stop_det) begin
      state_n = ST_IDLE;
      pull_n  = 1'b0;
    end else if (start_det) begin
      state_n = ST_CTRL;
      cnt_n   = 4'd0;
      pull_n  = 1'b0;
    end else if (scl_rise) begin
      if (state_q == ST_MACK) begin
        if (sda_lvl) begin
          state_n = ST_IDLE;
        end else begin
          state_n = ST_SEND;
          tx_n    = rdata;
          addr_n  = addr_q + ADDR_W'(1);
          cnt_n   = 4'd0;
          rd_load = 1'b1;
        end
      end else if (rx_state && !pull_q) begin
        rx_n  = {rx_q[6:0], sda_lvl};
        cnt_n = cnt_q + 4'd1;
      end
    end else if (scl_fall) begin
      if (rx_state && cnt_q == 4'd8) begin
        cnt_n  = 4'd0;
        pull_n = 1'b1;
        case (state_q)
          ST_CTRL: begin
            if (rx_q[7:4] != DEV_ID) begin
              state_n = ST_IDLE;
              pull_n  = 1'b0;
            end else if (rx_q[0]) begin
              state_n = ST_SEND;
              tx_n    = rdata;
              addr_n  = rd_addr + ADDR_W'(1);
              rd_load = 1'b1;
            end else begin
              addr_n[ADDR_W-1:8] = rx_q[BLK_W:1];
              state_n = ST_WADDR;
            end
          end
          ST_WADDR: begin
            addr_n[7:0] = rx_q;
            state_n     = ST_WDATA;
          end
          default: begin
            mem_we = 1'b1;
            addr_n = {addr_q[ADDR_W-1:PAGE_W], addr_q[PAGE_W-1:0] + 1'b1};
          end
        endcase
      end else if (state_q == ST_SEND) begin
        if (cnt_q == 4'd8) begin
          state_n = ST_MACK;
          pull_n  = 1'b0;
        end else begin
          pull_n = ~tx_q[7];
          tx_n   = {tx_q[6:0], 1'b0};
          cnt_n  = cnt_q + 4'd1;
        end
      end else begin
        pull_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      cnt_q   <= '0;
      pull_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      addr_q  <= addr_n;
      rx_q    <= rx_n;
      tx_q    <= tx_n;
      cnt_q   <= cnt_n;
      pull_q  <= pull_n;
    end
  end

  assign addr_o  = addr_q;
  assign wdata   = rx_q;
  assign pull_o  = pull_q;
  assign state_o = state_q;
endmodule

// File: rtl/twowire_eeprom_slave.sv
module twowire_eeprom_slave
  import twowire_eeprom_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int PAGE_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_pull_o
);
  logic              sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic [7:0]        rdata, wdata;
  logic [ADDR_W-1:0] rd_addr, addr;
  logic              mem_we, rd_load;
  ee_state_e         state;

  twowire_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  twowire_slave_fsm #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) fsm_i (
    .clk(clk), .rst_n(rst_n), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .rdata(rdata), .rd_addr(rd_addr), .addr_o(addr), .wdata(wdata),
    .mem_we(mem_we), .rd_load(rd_load), .pull_o(sda_pull_o), .state_o(state)
  );

  twowire_byte_store #(.ADDR_W(ADDR_W), .DATA_W(8)) store_i (
    .clk(clk), .we(mem_we), .waddr(addr), .wdata(wdata),
    .raddr(rd_addr), .rdata(rdata)
  );
endmodule

// File: rtl/twowire_eeprom_chk.sv
module twowire_eeprom_chk
  import twowire_eeprom_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_pull_o,
  input ee_state_e         state,
  input logic [ADDR_W-1:0] addr,
  input logic              mem_we,
  input logic              rd_load,
  input logic              start_det,
  input logic              stop_det
);
  a_r2_pull_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull_o != $past(sda_pull_o)) |-> !scl_i);

  a_r1_start_enters_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && !stop_det) |=> (state == ST_CTRL));

  a_r1_stop_goes_idle: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (state == ST_IDLE) && !sda_pull_o);

  a_r3_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_pull_o);

  a_r6_page_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (addr[ADDR_W-1:4] == $past(addr[ADDR_W-1:4])) &&
               (addr[3:0] == $past(addr[3:0]) + 4'd1));

  a_r7_read_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_load && state == ST_MACK) |=> (addr == $past(addr) + ADDR_W'(1)));
endmodule

bind twowire_eeprom_slave twowire_eeprom_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_pull_o(sda_pull_o),
  .state(state), .addr(addr), .mem_we(mem_we), .rd_load(rd_load),
  .start_det(start_det), .stop_det(stop_det)
);

// File: tb/twowire_eeprom_slave_tb.sv
`timescale 1ns/1ps
module twowire_eeprom_slave_tb_top;
  localparam int Q = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_pull;
  logic sda_line;
  int   n_chk = 0;
  int   n_fail = 0;
  int   hi_moves = 0;
  logic pull_prev = 1'b0;
  logic [7:0] wbuf [16];
  logic [7:0] rbuf [16];

  assign sda_line = sda_m & ~sda_pull;

  always #4 clk = ~clk;

  twowire_eeprom_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_pull_o(sda_pull)
  );

  always @(negedge clk) begin
    if (rst_n && scl && (sda_pull !== pull_prev)) hi_moves++;
    pull_prev <= sda_pull;
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wait_q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_q();
    scl = 1'b1; wait_q();
    sda_m = 1'b0; wait_q();
    scl = 1'b0; wait_q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_q();
    scl = 1'b1; wait_q();
    sda_m = 1'b1; wait_q();
  endtask

  task automatic clk_bit(input logic b, output logic r);
    sda_m = b; wait_q();
    scl = 1'b1; wait_q();
    r = sda_line; wait_q();
    scl = 1'b0; wait_q();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], r);
    clk_bit(1'b1, r);
    ack = ~r;
  endtask

  task automatic recv_byte(input logic m_ack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, r);
      d[i] = r;
    end
    clk_bit(~m_ack, r);
  endtask

  // R5 R8: control, word address, then n data bytes from wbuf
  task automatic write_bytes(input logic [10:0] a, input int n);
    logic ack;
    bus_start();
    send_byte({4'b1010, a[10:8], 1'b0}, ack); chk("R8 ctrl ack", {7'd0, ack}, 8'd1);
    send_byte(a[7:0], ack);                   chk("R8 addr ack", {7'd0, ack}, 8'd1);
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], ack);                chk("R8 data ack", {7'd0, ack}, 8'd1);
    end
    bus_stop();
  endtask

  // R9: dummy write sets address, repeated start, sequential read
  task automatic read_bytes(input logic [10:0] a, input int n);
    logic ack;
    logic [7:0] d;
    bus_start();
    send_byte({4'b1010, a[10:8], 1'b0}, ack);
    send_byte(a[7:0], ack);
    bus_start();
    send_byte({4'b1010, a[10:8], 1'b1}, ack); chk("R4 read ctrl ack", {7'd0, ack}, 8'd1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, d);
      rbuf[i] = d;
    end
    bus_stop();
  endtask

  task automatic t_reset();
    chk("R10 reset release", {7'd0, sda_pull}, 8'd0);
    chk("R10 idle line", {7'd0, sda_line}, 8'd1);
  endtask

  task automatic t_bad_ctrl();
    logic ack;
    bus_start();
    send_byte(8'hB0, ack); chk("R3 bad id no ack", {7'd0, ack}, 8'd0);
    send_byte(8'h00, ack); chk("R3 stays idle", {7'd0, ack}, 8'd0);
    bus_stop();
  endtask

  task automatic t_seq_write_read();
    wbuf[0] = 8'h81; wbuf[1] = 8'h3C; wbuf[2] = 8'hE7; wbuf[3] = 8'h05;
    write_bytes(11'h123, 4);
    read_bytes(11'h123, 4);
    chk("R5 byte0", rbuf[0], 8'h81);
    chk("R2 msb order", rbuf[1], 8'h3C);
    chk("R9 seq byte2", rbuf[2], 8'hE7);
    chk("R9 seq byte3", rbuf[3], 8'h05);
  endtask

  task automatic t_block_bits();
    wbuf[0] = 8'hA5;
    write_bytes(11'h523, 1);
    read_bytes(11'h523, 1); chk("R4 block 5 data", rbuf[0], 8'hA5);
    read_bytes(11'h123, 1); chk("R4 block 1 kept", rbuf[0], 8'h81);
  endtask

  task automatic t_page_wrap();
    wbuf[0] = 8'h5A;
    write_bytes(11'h210, 1);
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    write_bytes(11'h20E, 3);
    read_bytes(11'h200, 1); chk("R6 wrapped to 0x200", rbuf[0], 8'h33);
    read_bytes(11'h20E, 3);
    chk("R6 0x20E", rbuf[0], 8'h11);
    chk("R6 0x20F", rbuf[1], 8'h22);
    chk("R7 read crosses page to 0x210", rbuf[2], 8'h5A);
  endtask

  task automatic t_top_wrap_and_current();
    logic ack;
    logic [7:0] d;
    wbuf[0] = 8'h77;
    write_bytes(11'h7FF, 1);
    wbuf[0] = 8'h4E; wbuf[1] = 8'hC2;
    write_bytes(11'h000, 2);
    read_bytes(11'h7FF, 2);
    chk("R7 0x7FF", rbuf[0], 8'h77);
    chk("R7 wrap to 0x000", rbuf[1], 8'h4E);
    bus_start();
    send_byte(8'hA1, ack); chk("R4 current read ack", {7'd0, ack}, 8'd1);
    recv_byte(1'b0, d);    chk("R4 current address", d, 8'hC2);
    recv_byte(1'b0, d);    chk("R9 nack releases", d, 8'hFF);
    bus_stop();
  endtask

  task automatic t_stop_abort();
    logic ack;
    wbuf[0] = 8'h33;
    write_bytes(11'h030, 1);
    bus_start();
    send_byte(8'hA0, ack);
    send_byte(8'h30, ack);
    bus_stop();
    send_byte(8'h99, ack); chk("R1 no ack after stop", {7'd0, ack}, 8'd0);
    bus_stop();
    bus_start();
    send_byte(8'hA0, ack);
    send_byte(8'h30, ack);
    bus_start();
    send_byte(8'hA1, ack); chk("R1 start restarts", {7'd0, ack}, 8'd1);
    recv_byte(1'b0, rbuf[0]);
    bus_stop();
    chk("R1 stop kept data", rbuf[0], 8'h33);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_bad_ctrl();
    t_seq_write_read();
    t_block_bits();
    t_page_wrap();
    t_top_wrap_and_current();
    t_stop_abort();
    chk("R2 pull still while SCL high", hi_moves[7:0], 8'd0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule